// File: doc/BRIEF.md
# Capability Access Check Unit

This unit sits between a load/store pipeline and memory and guards every memory access made through a capability. A capability here is an address plus uncompressed metadata: a base, a top (one past the last reachable byte), a permission set, and a validity tag that travels beside the value. For each access the unit reports whether it may proceed. When it may not, the unit gives a single fault code chosen by a fixed priority. An access that fails its check must not be sent on to memory.

A second channel derives new capabilities from existing ones. It can narrow the bounds to a byte window that starts at the current address. It can also replace the permission set with a subset of the current one. A request that would widen the rights still returns a result, but with the tag cleared and a fault flag raised, so the result can never be used for an access.

Both channels are streams with valid/ready handshakes and one registered output stage each. A channel accepts an input whenever its output register is empty or is being drained in the same cycle (`ready = !out_valid || out_ready`). A result is held unchanged while the consumer holds `ready` low. With the consumer always ready, each channel takes one request every cycle.

Top module: `cap_guard`

## Requirements
- R1: An access through a capability whose tag is 0 gives pass 0 and fault code 1 (tag).
- R2: An access of `size` bytes at `addr` passes the range check only when base <= addr and addr + size <= top. An access ending exactly at top passes. An access one byte past top, or one starting below base, gives fault code 3 (bounds).
- R3: The sum addr + size is formed one bit wider than the address, so it cannot wrap. With base 0, top 2^64 and addr all ones, size 1 passes and size 2 gives a bounds fault.
- R4: Permission bits are bit 0 load, bit 1 store, bit 2 load-capability and bit 3 store-capability. A read needs load and a write needs store. A capability-width access (`acc_cap` = 1) also needs load-capability for a read, or store-capability for a write. A missing bit gives fault code 2 (permission).
- R5: When several faults apply, only one is reported, in this order: tag, then permission, then bounds. Pass is 1 only with fault code 0.
- R6: Set-bounds (op 0) gives new base = addr and new top = addr + len. When the window lies inside the source, the result keeps tag 1, keeps the permissions and address, and has fault 0 and code 0. A 32-byte window allows exactly 32 bytes to be reached.
- R7: A set-bounds request whose window starts below the source base, or ends above the source top, returns tag 0 with fault 1 and code 3.
- R8: Set-permissions (op 1) returns the requested set with tag 1 when that set is a subset of the source. If the request has any bit the source lacks, the result has tag 0, fault 1 and code 2.
- R9: Deriving from a source whose tag is 0 returns tag 0, fault 1 and code 1, whatever the request.
- R10: Each channel has one output register. Input ready is `!out_valid || out_ready`. A result is held stable while out_valid is 1 and out_ready is 0. Back-to-back requests are accepted every cycle and come out in order.
- R11: After reset both output valids are 0 and both input readies are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Access request valid |
| acc_ready | output | 1 | Access request accepted |
| acc_tag | input | 1 | Validity tag of the capability |
| acc_base | input | AW | Lowest reachable byte |
| acc_top | input | AW+1 | One past the highest reachable byte |
| acc_perm | input | PW | Permission set |
| acc_addr | input | AW | Access address |
| acc_size | input | SZW | Access size in bytes |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_cap | input | 1 | Capability-width transfer |
| res_valid | output | 1 | Access verdict valid |
| res_ready | input | 1 | Consumer takes verdict |
| res_pass | output | 1 | Access may proceed |
| res_fault | output | 2 | 0 none, 1 tag, 2 permission, 3 bounds |
| drv_valid | input | 1 | Derive request valid |
| drv_ready | output | 1 | Derive request accepted |
| drv_tag | input | 1 | Source tag |
| drv_base | input | AW | Source base |
| drv_top | input | AW+1 | Source top |
| drv_perm | input | PW | Source permissions |
| drv_addr | input | AW | Source address |
| drv_op | input | 1 | 0 set-bounds, 1 set-permissions |
| drv_len | input | AW | Window length for set-bounds |
| drv_perm_req | input | PW | Requested permissions |
| dout_valid | output | 1 | Derived capability valid |
| dout_ready | input | 1 | Consumer takes derived capability |
| dout_tag | output | 1 | Derived tag |
| dout_base | output | AW | Derived base |
| dout_top | output | AW+1 | Derived top |
| dout_perm | output | PW | Derived permissions |
| dout_addr | output | AW | Derived address |
| dout_fault | output | 1 | Derivation refused |
| dout_code | output | 2 | Refusal reason, same encoding as res_fault |

## Verification
The hardest case to reach is the wrap-around edge. It needs a capability that spans the whole address space, with top at 2^64, which only the extra top bit can express, and an access at the very last address. The bench builds that capability directly and sends two accesses whose sums land one on each side of 2^64. The hold-under-back-pressure case is also reached on purpose: the result consumer is stalled while a second request waits at the input. The bench then checks that the held verdict is unchanged and that the waiting request comes out once the stall ends.

// File: rtl/cap_guard_pkg.sv
package cap_guard_pkg;
  typedef enum logic [1:0] {
    FLT_NONE   = 2'd0,
    FLT_TAG    = 2'd1,
    FLT_PERM   = 2'd2,
    FLT_BOUNDS = 2'd3
  } flt_e;

  localparam int PERM_LD = 0;
  localparam int PERM_ST = 1;
  localparam int PERM_LC = 2;
  localparam int PERM_SC = 3;

  localparam logic OP_BOUNDS = 1'b0;
  localparam logic OP_PERMS  = 1'b1;
endpackage

// File: rtl/cap_access_chk.sv
module cap_access_chk
  import cap_guard_pkg::*;
#(
  parameter int AW  = 64,
  parameter int PW  = 4,
  parameter int SZW = 5
) (
  input  logic          tag,
  input  logic [AW-1:0] base,
  input  logic [AW:0]   top,
  input  logic [PW-1:0] perm,
  input  logic [AW-1:0] addr,
  input  logic [SZW-1:0] size,
  input  logic          wr,
  input  logic          capw,
  output flt_e          fault
);
  localparam int PADW = AW + 1 - SZW;

  logic [AW:0]   end_addr;
  logic [PW-1:0] need;
  logic          perm_ok;
  logic          range_ok;

  // one extra bit so the end of the access cannot wrap back into range
  assign end_addr = {1'b0, addr} + {{PADW{1'b0}}, size};

  always_comb begin
    need = '0;
    if (wr) need[PERM_ST] = 1'b1;
    else    need[PERM_LD] = 1'b1;
    if (capw) begin
      if (wr) need[PERM_SC] = 1'b1;
      else    need[PERM_LC] = 1'b1;
    end
  end

  assign perm_ok  = (need & ~perm) == '0;
  assign range_ok = (addr >= base) && (end_addr <= top);

  // priority: tag, then permission, then range
  always_comb begin
    if (!tag)           fault = FLT_TAG;
    else if (!perm_ok)  fault = FLT_PERM;
    else if (!range_ok) fault = FLT_BOUNDS;
    else                fault = FLT_NONE;
  end
endmodule

// File: rtl/cap_derive_chk.sv
module cap_derive_chk
  import cap_guard_pkg::*;
#(
  parameter int AW = 64,
  parameter int PW = 4
) (
  input  logic          src_tag,
  input  logic [AW-1:0] src_base,
  input  logic [AW:0]   src_top,
  input  logic [PW-1:0] src_perm,
  input  logic [AW-1:0] src_addr,
  input  logic          op,
  input  logic [AW-1:0] len,
  input  logic [PW-1:0] perm_req,
  output logic          r_tag,
  output logic [AW-1:0] r_base,
  output logic [AW:0]   r_top,
  output logic [PW-1:0] r_perm,
  output logic [AW-1:0] r_addr,
  output logic          r_fault,
  output flt_e          r_code
);
  logic [AW:0] win_top;
  logic        win_ok;
  logic        subset_ok;

  assign win_top   = {1'b0, src_addr} + {1'b0, len};
  assign win_ok    = (src_addr >= src_base) && (win_top <= src_top);
  assign subset_ok = (perm_req & ~src_perm) == '0;

  always_comb begin
    r_addr = src_addr;
    if (op == OP_BOUNDS) begin
      r_base = src_addr;
      r_top  = win_top;
      r_perm = src_perm;
    end else begin
      r_base = src_base;
      r_top  = src_top;
      r_perm = perm_req;
    end
    if (!src_tag)                        r_code = FLT_TAG;
    else if (op == OP_BOUNDS && !win_ok) r_code = FLT_BOUNDS;
    else if (op == OP_PERMS && !subset_ok) r_code = FLT_PERM;
    else                                 r_code = FLT_NONE;
    r_fault = (r_code != FLT_NONE);
    r_tag   = !r_fault;
  end
endmodule

// File: rtl/cap_stage.sv
module cap_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        out_valid <= 1'b0;
    else if (in_ready) out_valid <= in_valid;
  end

  always_ff @(posedge clk) begin
    if (in_valid && in_ready) out_data <= in_data;
  end

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)))
    else $error("stalled result changed");

  p_accept_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid)
    else $error("accepted request produced no result");
endmodule

// File: rtl/cap_guard.sv
module cap_guard
  import cap_guard_pkg::*;
#(
  parameter int AW  = 64,
  parameter int PW  = 4,
  parameter int SZW = 5
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           acc_valid,
  output logic           acc_ready,
  input  logic           acc_tag,
  input  logic [AW-1:0]  acc_base,
  input  logic [AW:0]    acc_top,
  input  logic [PW-1:0]  acc_perm,
  input  logic [AW-1:0]  acc_addr,
  input  logic [SZW-1:0] acc_size,
  input  logic           acc_write,
  input  logic           acc_cap,
  output logic           res_valid,
  input  logic           res_ready,
  output logic           res_pass,
  output logic [1:0]     res_fault,
  input  logic           drv_valid,
  output logic           drv_ready,
  input  logic           drv_tag,
  input  logic [AW-1:0]  drv_base,
  input  logic [AW:0]    drv_top,
  input  logic [PW-1:0]  drv_perm,
  input  logic [AW-1:0]  drv_addr,
  input  logic           drv_op,
  input  logic [AW-1:0]  drv_len,
  input  logic [PW-1:0]  drv_perm_req,
  output logic           dout_valid,
  input  logic           dout_ready,
  output logic           dout_tag,
  output logic [AW-1:0]  dout_base,
  output logic [AW:0]    dout_top,
  output logic [PW-1:0]  dout_perm,
  output logic [AW-1:0]  dout_addr,
  output logic           dout_fault,
  output logic [1:0]     dout_code
);
  localparam int RW = 3;
  localparam int DW = 3 * AW + PW + 5;

  flt_e          acc_flt;
  logic [RW-1:0] res_in, res_q;

  cap_access_chk #(.AW(AW), .PW(PW), .SZW(SZW)) u_acc (
    .tag(acc_tag), .base(acc_base), .top(acc_top), .perm(acc_perm),
    .addr(acc_addr), .size(acc_size), .wr(acc_write), .capw(acc_cap),
    .fault(acc_flt)
  );

  assign res_in = {(acc_flt == FLT_NONE), acc_flt};

  cap_stage #(.W(RW)) u_res_stage (
    .clk(clk), .rst_n(rst_n),
    .in_valid(acc_valid), .in_ready(acc_ready), .in_data(res_in),
    .out_valid(res_valid), .out_ready(res_ready), .out_data(res_q)
  );

  assign res_pass  = res_q[2];
  assign res_fault = res_q[1:0];

  logic          d_tag, d_fault;
  logic [AW-1:0] d_base, d_addr;
  logic [AW:0]   d_top;
  logic [PW-1:0] d_perm;
  flt_e          d_code;
  logic [DW-1:0] dout_in, dout_q;

  cap_derive_chk #(.AW(AW), .PW(PW)) u_drv (
    .src_tag(drv_tag), .src_base(drv_base), .src_top(drv_top),
    .src_perm(drv_perm), .src_addr(drv_addr), .op(drv_op), .len(drv_len),
    .perm_req(drv_perm_req),
    .r_tag(d_tag), .r_base(d_base), .r_top(d_top), .r_perm(d_perm),
    .r_addr(d_addr), .r_fault(d_fault), .r_code(d_code)
  );

  assign dout_in = {d_tag, d_base, d_top, d_perm, d_addr, d_fault, d_code};

  cap_stage #(.W(DW)) u_drv_stage (
    .clk(clk), .rst_n(rst_n),
    .in_valid(drv_valid), .in_ready(drv_ready), .in_data(dout_in),
    .out_valid(dout_valid), .out_ready(dout_ready), .out_data(dout_q)
  );

  assign {dout_tag, dout_base, dout_top, dout_perm, dout_addr, dout_fault, dout_code} = dout_q;

  // ---------------- assertions ----------------
  logic [AW:0] acc_end_a;
  assign acc_end_a = {1'b0, acc_addr} + {{(AW + 1 - SZW){1'b0}}, acc_size};

  p_untagged_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_ready && !acc_tag) |=> (!res_pass && res_fault == 2'd1))
    else $error("untagged access not refused");

  p_pass_in_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_ready && acc_addr >= acc_base && acc_end_a <= acc_top)
      |=> (res_fault != 2'd3))
    else $error("in-range access given bounds fault");

  p_pass_needs_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_ready && acc_end_a > acc_top) |=> !res_pass)
    else $error("access past top passed");

  p_monotone_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (drv_valid && drv_ready) |=>
      (!dout_tag || (dout_base >= $past(drv_base) && dout_top <= $past(drv_top)
                     && (dout_perm & ~$past(drv_perm)) == '0)))
    else $error("derived capability wider than source");

  p_widen_perm_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (drv_valid && drv_ready && drv_tag && drv_op == OP_PERMS && (drv_perm_req & ~drv_perm) != '0)
      |=> (!dout_tag && dout_fault && dout_code == 2'd2))
    else $error("permission widening not refused");

  p_untagged_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (drv_valid && drv_ready && !drv_tag) |=> (!dout_tag && dout_fault && dout_code == 2'd1))
    else $error("derive from untagged source not refused");
endmodule

// File: tb/cap_guard_test.sv
module cap_guard_test;
  localparam int AW = 64;
  localparam int PW = 4;
  localparam int SZW = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic acc_valid = 0, acc_ready, acc_tag = 0, acc_write = 0, acc_cap = 0;
  logic [AW-1:0] acc_base = '0, acc_addr = '0;
  logic [AW:0] acc_top = '0;
  logic [PW-1:0] acc_perm = '0;
  logic [SZW-1:0] acc_size = '0;
  logic res_valid, res_ready = 1, res_pass;
  logic [1:0] res_fault;
  logic drv_valid = 0, drv_ready, drv_tag = 0, drv_op = 0;
  logic [AW-1:0] drv_base = '0, drv_addr = '0, drv_len = '0;
  logic [AW:0] drv_top = '0;
  logic [PW-1:0] drv_perm = '0, drv_perm_req = '0;
  logic dout_valid, dout_ready = 1, dout_tag, dout_fault;
  logic [AW-1:0] dout_base, dout_addr;
  logic [AW:0] dout_top;
  logic [PW-1:0] dout_perm;
  logic [1:0] dout_code;

  cap_guard #(.AW(AW), .PW(PW), .SZW(SZW)) uut (.*);

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  task automatic chk(input string req, input logic [AW:0] act, input logic [AW:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  // drive one access, sample its verdict one cycle later
  task automatic acc_run(input logic t, input logic [AW-1:0] b, input logic [AW:0] tp,
                         input logic [PW-1:0] p, input logic [AW-1:0] a,
                         input logic [SZW-1:0] s, input logic w, input logic c,
                         output logic ok, output logic [1:0] f);
    @(negedge clk);
    acc_tag = t; acc_base = b; acc_top = tp; acc_perm = p;
    acc_addr = a; acc_size = s; acc_write = w; acc_cap = c; acc_valid = 1;
    @(negedge clk);
    acc_valid = 0;
    ok = res_pass; f = res_fault;
  endtask

  task automatic drv_run(input logic t, input logic [AW-1:0] b, input logic [AW:0] tp,
                         input logic [PW-1:0] p, input logic [AW-1:0] a,
                         input logic op, input logic [AW-1:0] len, input logic [PW-1:0] pr);
    @(negedge clk);
    drv_tag = t; drv_base = b; drv_top = tp; drv_perm = p; drv_addr = a;
    drv_op = op; drv_len = len; drv_perm_req = pr; drv_valid = 1;
    @(negedge clk);
    drv_valid = 0;
  endtask

  logic ok;
  logic [1:0] f;

  task automatic t_reset();
    chk("R11 res_valid", res_valid, 0);
    chk("R11 dout_valid", dout_valid, 0);
    chk("R11 acc_ready", acc_ready, 1);
    chk("R11 drv_ready", drv_ready, 1);
  endtask

  task automatic t_bounds();
    acc_run(1, 64'h1000, 65'h1040, 4'hF, 64'h1000, 8, 0, 0, ok, f);
    chk("R2 inside pass", ok, 1); chk("R2 inside code", f, 0);
    acc_run(1, 64'h1000, 65'h1040, 4'hF, 64'h1038, 8, 0, 0, ok, f);
    chk("R2 end at top", ok, 1);
    acc_run(1, 64'h1000, 65'h1040, 4'hF, 64'h1039, 8, 0, 0, ok, f);
    chk("R2 one past top", f, 3); chk("R2 one past top pass", ok, 0);
    acc_run(1, 64'h1000, 65'h1040, 4'hF, 64'h0FFF, 1, 1, 0, ok, f);
    chk("R2 below base", f, 3);
  endtask

  task automatic t_wrap();
    acc_run(1, 64'h0, 65'h1_0000_0000_0000_0000, 4'hF, 64'hFFFF_FFFF_FFFF_FFFF, 1, 0, 0, ok, f);
    chk("R3 last byte", ok, 1);
    acc_run(1, 64'h0, 65'h1_0000_0000_0000_0000, 4'hF, 64'hFFFF_FFFF_FFFF_FFFF, 2, 0, 0, ok, f);
    chk("R3 wrap refused", f, 3);
  endtask

  task automatic t_tag();
    acc_run(0, 64'h1000, 65'h1040, 4'hF, 64'h1000, 4, 0, 0, ok, f);
    chk("R1 tag code", f, 1); chk("R1 tag pass", ok, 0);
  endtask

  task automatic t_perm();
    acc_run(1, 64'h1000, 65'h1040, 4'b0001, 64'h1000, 4, 1, 0, ok, f);
    chk("R4 write no store", f, 2);
    acc_run(1, 64'h1000, 65'h1040, 4'b0001, 64'h1000, 4, 0, 0, ok, f);
    chk("R4 read with load", ok, 1);
    acc_run(1, 64'h1000, 65'h1040, 4'b0001, 64'h1000, 16, 0, 1, ok, f);
    chk("R4 cap read no LC", f, 2);
    acc_run(1, 64'h1000, 65'h1040, 4'b0101, 64'h1000, 16, 0, 1, ok, f);
    chk("R4 cap read with LC", ok, 1);
    acc_run(1, 64'h1000, 65'h1040, 4'b1010, 64'h1010, 16, 1, 1, ok, f);
    chk("R4 cap write with SC", ok, 1);
    acc_run(1, 64'h1000, 65'h1040, 4'b0010, 64'h1010, 16, 1, 1, ok, f);
    chk("R4 cap write no SC", f, 2);
  endtask

  task automatic t_priority();
    acc_run(0, 64'h1000, 65'h1040, 4'b0000, 64'h2000, 4, 1, 0, ok, f);
    chk("R5 tag first", f, 1);
    acc_run(1, 64'h1000, 65'h1040, 4'b0000, 64'h2000, 4, 1, 0, ok, f);
    chk("R5 perm before bounds", f, 2); chk("R5 no pass", ok, 0);
  endtask

  task automatic t_setbounds();
    logic [AW-1:0] nb;
    logic [AW:0] nt;
    drv_run(1, 64'h1000, 65'h1040, 4'hF, 64'h1010, 0, 64'd32, 4'h0);
    chk("R6 tag kept", dout_tag, 1); chk("R6 base", dout_base, 64'h1010);
    chk("R6 top", dout_top, 65'h1030); chk("R6 perm", dout_perm, 4'hF);
    chk("R6 fault", dout_fault, 0); chk("R6 code", dout_code, 0);
    nb = dout_base; nt = dout_top;
    acc_run(1, nb, nt, 4'hF, 64'h1010 + 31, 1, 0, 0, ok, f);
    chk("R6 byte 31 reachable", ok, 1);
    acc_run(1, nb, nt, 4'hF, 64'h1010 + 32, 1, 0, 0, ok, f);
    chk("R6 byte 32 blocked", f, 3);
  endtask

  task automatic t_widen_bounds();
    drv_run(1, 64'h1000, 65'h1040, 4'hF, 64'h1030, 0, 64'h20, 4'h0);
    chk("R7 over top tag", dout_tag, 0); chk("R7 over top fault", dout_fault, 1);
    chk("R7 over top code", dout_code, 3);
    drv_run(1, 64'h1000, 65'h1040, 4'hF, 64'h0FF0, 0, 64'h8, 4'h0);
    chk("R7 below base tag", dout_tag, 0); chk("R7 below base code", dout_code, 3);
  endtask

  task automatic t_perms();
    drv_run(1, 64'h1000, 65'h1040, 4'hF, 64'h1000, 1, 64'h0, 4'b0001);
    chk("R8 subset tag", dout_tag, 1); chk("R8 subset perm", dout_perm, 4'b0001);
    chk("R8 subset bounds", dout_top, 65'h1040);
    drv_run(1, 64'h1000, 65'h1040, 4'b0001, 64'h1000, 1, 64'h0, 4'b0011);
    chk("R8 widen tag", dout_tag, 0); chk("R8 widen fault", dout_fault, 1);
    chk("R8 widen code", dout_code, 2);
  endtask

  task automatic t_untagged_src();
    drv_run(0, 64'h1000, 65'h1040, 4'hF, 64'h1010, 0, 64'h4, 4'h0);
    chk("R9 tag", dout_tag, 0); chk("R9 code", dout_code, 1);
  endtask

  task automatic t_stream();
    // back-to-back, consumer ready
    res_ready = 1;
    @(negedge clk);
    acc_tag = 1; acc_base = 64'h1000; acc_top = 65'h1040; acc_perm = 4'hF;
    acc_addr = 64'h1000; acc_size = 4; acc_write = 0; acc_cap = 0; acc_valid = 1;
    @(negedge clk);
    chk("R10 ready streaming", acc_ready, 1);
    chk("R10 first out", res_fault, 0);
    acc_tag = 0;
    @(negedge clk);
    chk("R10 second out", res_fault, 1);
    acc_tag = 1; acc_addr = 64'h1040;
    @(negedge clk);
    acc_valid = 0;
    chk("R10 third out", res_fault, 3);
    // stall
    @(negedge clk);
    res_ready = 0;
    acc_tag = 1; acc_addr = 64'h1000; acc_valid = 1;
    @(negedge clk);
    acc_tag = 0;
    chk("R10 held valid", res_valid, 1);
    chk("R10 blocked ready", acc_ready, 0);
    @(negedge clk);
    chk("R10 held pass", res_pass, 1); chk("R10 held code", res_fault, 0);
    res_ready = 1;
    @(negedge clk);
    acc_valid = 0;
    chk("R10 waiting one out", res_fault, 1);
    @(negedge clk);
    chk("R10 drained", res_valid, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    t_bounds();
    t_wrap();
    t_tag();
    t_perm();
    t_priority();
    t_setbounds();
    t_widen_bounds();
    t_perms();
    t_untagged_src();
    t_stream();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(5.0 * 100000);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule